// File: doc/BRIEF.md
# Ring-Buffer Memory-to-Peripheral DMA Channel

This block is one DMA channel that streams 32-bit words out of a circular buffer in memory into a single peripheral data register, which is the usual feed for an audio serializer. Each pulse on the request input moves one burst (a "minor loop") of a programmable number of words. A programmable count of bursts forms a "major loop". When the major loop ends, the channel raises a one-cycle interrupt, reloads its burst counter and keeps going on its own.

The source pointer steps by one word per transfer. Only its low `cfg_src_mod` address bits take part in the increment, and the bits above them never change. The buffer therefore behaves as a hardware ring aligned to a power of two. As an example, a setting of 17 gives a 128 KiB ring, and a setting of 0 turns the wrap off. The destination address stays the same for every write. The remaining-bursts counter is visible on an output, so software can work out the playback position within the ring.

Both data ports follow valid/ready rules. The read request (`rd_valid`, `rd_addr`) and the write (`wr_valid`, `wr_addr`, `wr_data`) are held stable until the matching ready is seen high at a clock edge, so the memory and the peripheral can stall for as long as they need. The channel keeps only one read in flight. Its response port has no ready: the channel accepts the single `rsp_valid` beat whenever it arrives. Configuration must stay static while `cfg_en` is high or a burst is in progress. `cfg_minor_words` and `cfg_major_count` must be at least 1.

Top module: `dma_ring_chan`

## Requirements
- R1: During reset and directly after it, `rd_valid`, `wr_valid` and `irq` are 0 and `cur_iter` is 0.
- R2: With `cfg_en` high, each serviced request performs exactly `cfg_minor_words` read/write transfers. No read is issued without a request.
- R3: Every transfer writes the word returned for its read, unchanged, to `cfg_dst_addr`. The destination address never advances.
- R4: After each transfer the source address increases by 4 within a window of 2^`cfg_src_mod` bytes. Address bits at and above position `cfg_src_mod` keep their value. `cfg_src_mod` = 0 gives a plain linear increment.
- R5: `cur_iter` holds the number of bursts left in the major loop. It drops by one when a burst's last write is accepted and stays unchanged during a burst.
- R6: When the last burst of a major loop ends, `irq` is high for exactly one cycle and `cur_iter` reloads to `cfg_major_count`. The source address carries on from where it stopped, with no end-of-loop adjustment.
- R7: A request that arrives while a burst runs is held and served right after that burst. Several such requests collapse into one pending burst.
- R8: While `rd_valid` is high and `rd_ready` low, `rd_valid` and `rd_addr` stay unchanged on the next cycle. While `wr_valid` is high and `wr_ready` low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged on the next cycle.
- R9: While `cfg_en` is low and the channel is idle, requests are ignored and not remembered. The source pointer reloads from `cfg_src_base` and `cur_iter` reloads from `cfg_major_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_src_base | input | ADDR_W | Ring start address loaded while disabled |
| cfg_src_mod | input | MOD_W | Wrap window exponent (0 = no wrap) |
| cfg_dst_addr | input | ADDR_W | Fixed peripheral register address |
| cfg_minor_words | input | WCNT_W | Words per burst (>= 1) |
| cfg_major_count | input | ITER_W | Bursts per major loop (>= 1) |
| req | input | 1 | Peripheral request pulse |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts read request |
| rd_addr | output | ADDR_W | Read address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DATA_W | Read data |
| wr_valid | output | 1 | Peripheral write valid |
| wr_ready | input | 1 | Peripheral accepts write |
| wr_addr | output | ADDR_W | Peripheral write address |
| wr_data | output | DATA_W | Peripheral write data |
| cur_iter | output | ITER_W | Bursts remaining in the major loop |
| irq | output | 1 | One-cycle major-loop-done pulse |

## Verification
The bench runs the ring across its wrap point. A pointer that carries into the upper bits would send reads outside the buffer, and a pointer that clears them would jump back to address zero. It also runs a linear pass across a 64 KiB boundary. It sends extra requests in the middle of a burst, which catches a design that drops them or serves each one separately, and it checks that requests made while disabled leave no burst behind. It drives the major-loop boundary and checks for a single interrupt with the counter reloaded and the source pointer continuing. Random-looking stalls on both ready inputs expose any request that changes or drops before it has been accepted.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WAIT  = 2'd2,
    XS_WRITE = 2'd3
  } xfer_st_e;
endpackage

// File: rtl/dma_ring_addr.sv
module dma_ring_addr #(
  parameter int ADDR_W     = 32,
  parameter int MOD_W      = 6,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [MOD_W-1:0]  mod,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] nxt;

  // mask selects the bits that move; 0 or an oversize exponent means all bits
  always_comb begin
    mask = (mod == '0) ? '1 : ((ONE << mod) - ONE);
    nxt  = (addr & ~mask) | ((addr + INC) & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= nxt;
  end

  // R4: bits above the window never change on a step
  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ((addr & ~$past(mask)) == ($past(addr) & ~$past(mask))));
  // R4: linear mode adds a word
  a_r4_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mod == '0) |=> (addr == $past(addr) + INC));
endmodule

// File: rtl/dma_ring_ctr.sv
module dma_ring_ctr #(
  parameter int ITER_W = 16,
  parameter int WCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic [ITER_W-1:0] major,
  input  logic [WCNT_W-1:0] minor,
  input  logic              start,
  input  logic              beat,
  output logic              last_beat,
  output logic [ITER_W-1:0] cur_iter,
  output logic              irq
);
  logic [WCNT_W-1:0] words_left;

  assign last_beat = (words_left == WCNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_left <= '0;
      cur_iter   <= '0;
      irq        <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start)     words_left <= minor;
      else if (beat) words_left <= words_left - WCNT_W'(1);
      if (reload) begin
        cur_iter <= major;
      end else if (beat && last_beat) begin
        if (cur_iter == ITER_W'(1)) begin
          cur_iter <= major;
          irq      <= 1'b1;
        end else begin
          cur_iter <= cur_iter - ITER_W'(1);
        end
      end
    end
  end

  // R5: counter holds inside a burst
  a_r5_iter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last_beat && !reload) |=> $stable(cur_iter));
  // R6: a single-cycle interrupt
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6: end of major loop reloads and signals
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last_beat && !reload && cur_iter == ITER_W'(1)) |=> (irq && cur_iter == $past(major)));
endmodule

// File: rtl/dma_ring_fsm.sv
module dma_ring_fsm
  import dma_ring_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pend,
  input  logic rd_ready,
  input  logic rsp_valid,
  input  logic wr_ready,
  input  logic last_beat,
  output logic idle,
  output logic start,
  output logic rd_valid,
  output logic rd_hs,
  output logic rsp_take,
  output logic wr_valid,
  output logic wr_hs
);
  xfer_st_e st, st_n;

  assign idle     = (st == XS_IDLE);
  assign start    = idle && en && pend;
  assign rd_valid = (st == XS_READ);
  assign wr_valid = (st == XS_WRITE);
  assign rd_hs    = rd_valid && rd_ready;
  assign wr_hs    = wr_valid && wr_ready;
  assign rsp_take = (st == XS_WAIT) && rsp_valid;

  always_comb begin
    st_n = st;
    unique case (st)
      XS_IDLE:  if (start)    st_n = XS_READ;
      XS_READ:  if (rd_hs)    st_n = XS_WAIT;
      XS_WAIT:  if (rsp_take) st_n = XS_WRITE;
      XS_WRITE: if (wr_hs)    st_n = last_beat ? XS_IDLE : XS_READ;
      default:                st_n = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= XS_IDLE;
    else        st <= st_n;
  end
endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ITER_W = 16,
  parameter int WCNT_W = 8,
  parameter int MOD_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [MOD_W-1:0]  cfg_src_mod,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [WCNT_W-1:0] cfg_minor_words,
  input  logic [ITER_W-1:0] cfg_major_count,
  input  logic              req,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ITER_W-1:0] cur_iter,
  output logic              irq
);
  localparam int WORD_BYTES = DATA_W / 8;

  logic idle, start, rd_hs, rsp_take, wr_hs, last_beat, pend, reload;
  logic [DATA_W-1:0] data_q;

  assign reload  = idle && !cfg_en;
  assign wr_addr = cfg_dst_addr;
  assign wr_data = data_q;

  // one pending burst; requests while disabled are dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (!cfg_en) pend <= 1'b0;
    else              pend <= req | (pend & ~start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (rsp_take) data_q <= rsp_data;
  end

  dma_ring_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .pend(pend),
    .rd_ready(rd_ready), .rsp_valid(rsp_valid), .wr_ready(wr_ready),
    .last_beat(last_beat), .idle(idle), .start(start),
    .rd_valid(rd_valid), .rd_hs(rd_hs), .rsp_take(rsp_take),
    .wr_valid(wr_valid), .wr_hs(wr_hs)
  );

  dma_ring_addr #(.ADDR_W(ADDR_W), .MOD_W(MOD_W), .WORD_BYTES(WORD_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(reload), .base(cfg_src_base),
    .mod(cfg_src_mod), .step(rd_hs), .addr(rd_addr)
  );

  dma_ring_ctr #(.ITER_W(ITER_W), .WCNT_W(WCNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .reload(reload), .major(cfg_major_count),
    .minor(cfg_minor_words), .start(start), .beat(wr_hs),
    .last_beat(last_beat), .cur_iter(cur_iter), .irq(irq)
  );

  // R8: stalled read request holds
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  // R8: stalled write holds
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
  // R2: a burst begins only from a pending request
  a_r2_read_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !pend) |=> !rd_valid);
endmodule

// File: tb/dma_ring_chan_tb_top.sv
`timescale 1ns/1ps
module dma_ring_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [31:0] cfg_src_base = '0;
  logic [5:0]  cfg_src_mod = '0;
  logic [31:0] cfg_dst_addr = '0;
  logic [7:0]  cfg_minor_words = 8'd4;
  logic [15:0] cfg_major_count = 16'd3;
  logic        req = 1'b0;
  logic        rd_valid, wr_valid, irq;
  logic        rd_ready = 1'b0, rsp_valid = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [31:0] rsp_data = '0;
  logic [15:0] cur_iter;

  int checks = 0, errors = 0, wr_count = 0, irq_count = 0, cyc = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  logic [31:0] model_addr;

  always #5 clk = ~clk;

  dma_ring_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src_base(cfg_src_base),
    .cfg_src_mod(cfg_src_mod), .cfg_dst_addr(cfg_dst_addr),
    .cfg_minor_words(cfg_minor_words), .cfg_major_count(cfg_major_count),
    .req(req), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cur_iter(cur_iter), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
  endfunction

  function automatic logic [31:0] ring_next(input logic [31:0] a, input logic [5:0] m);
    logic [31:0] msk;
    if (m == 0) return a + 32'd4;
    msk = (32'h1 << m) - 32'h1;
    return (a & ~msk) | ((a + 32'd4) & msk);
  endfunction

  // driver: expectations for one burst
  task automatic push_burst();
    for (int i = 0; i < int'(cfg_minor_words); i++) begin
      exp_q.push_back({cfg_dst_addr, mem_word(model_addr)});
      model_addr = ring_next(model_addr, cfg_src_mod);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // memory / peripheral model and scoreboard monitor
  initial begin
    bit rsp_due = 0, rd_stall = 0, wr_stall = 0;
    logic [31:0] rsp_addr = '0, p_rd_addr = '0, p_wr_addr = '0, p_wr_data = '0;
    logic [63:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0;
      if (rsp_due) begin
        rsp_valid = 1'b1;
        rsp_data  = mem_word(rsp_addr);
        rsp_due   = 0;
      end
      if (rd_stall)
        check(rd_valid && rd_addr == p_rd_addr, "R8 read hold", {31'd0, rd_valid, rd_addr}, {32'd1, p_rd_addr});
      if (wr_stall)
        check(wr_valid && wr_data == p_wr_data && wr_addr == p_wr_addr, "R8 write hold",
              {wr_addr, wr_data}, {p_wr_addr, p_wr_data});
      rd_ready = (cyc % 3) != 0;
      wr_ready = (cyc % 4) != 1;
      if (rd_valid && rd_ready) begin
        rsp_due  = 1;
        rsp_addr = rd_addr;
      end
      rd_stall = rd_valid && !rd_ready;  p_rd_addr = rd_addr;
      wr_stall = wr_valid && !wr_ready;  p_wr_addr = wr_addr;  p_wr_data = wr_data;
      if (wr_valid && wr_ready) begin
        wr_count++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected write", {wr_addr, wr_data}, 64'd0);
        end else begin
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, "R3/R4 scoreboard", {wr_addr, wr_data}, e);
        end
      end
      if (irq) irq_count++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int wc;
    idle_cycles(2);
    // R1 reset state
    check(!rd_valid && !wr_valid && !irq, "R1 outputs in reset", {rd_valid, wr_valid, irq}, 0);
    check(cur_iter == 0, "R1 cur_iter in reset", cur_iter, 0);
    @(negedge clk) rst_n = 1'b1;
    check(!rd_valid && !wr_valid && !irq && cur_iter == 0, "R1 after reset",
          {rd_valid, wr_valid, irq, cur_iter}, 0);

    // ring of 32 bytes starting near its top
    cfg_src_base = 32'h1000_0018; cfg_src_mod = 6'd5;
    cfg_dst_addr = 32'h4000_0020; cfg_minor_words = 8'd4; cfg_major_count = 16'd3;
    model_addr = cfg_src_base;
    idle_cycles(2);
    check(cur_iter == 3, "R9 reload while disabled", cur_iter, 3);
    cfg_en = 1'b1;
    idle_cycles(10);
    check(wr_count == 0 && !rd_valid, "R2 no request no read", wr_count, 0);

    push_burst();
    pulse_req();
    idle_cycles(80);
    check(wr_count == 4, "R2 one burst count", wr_count, 4);
    check(exp_q.size() == 0, "R4 wrap burst drained", exp_q.size(), 0);
    check(cur_iter == 2, "R5 iter after burst", cur_iter, 2);

    // R7: extra requests during a burst collapse into one
    push_burst();
    push_burst();
    pulse_req();
    idle_cycles(3);
    pulse_req();
    idle_cycles(2);
    pulse_req();
    idle_cycles(200);
    check(wr_count == 12, "R7 pending collapse", wr_count, 12);
    check(irq_count == 1, "R6 single irq", irq_count, 1);
    check(cur_iter == 3, "R6 iter reload", cur_iter, 3);

    // R6: address continues after the major loop
    push_burst();
    pulse_req();
    idle_cycles(80);
    check(wr_count == 16 && exp_q.size() == 0, "R6 continue address", wr_count, 16);
    check(cur_iter == 2, "R5 iter new loop", cur_iter, 2);

    // R4 linear mode across a 64 KiB boundary
    cfg_en = 1'b0;
    idle_cycles(2);
    check(cur_iter == 3, "R9 iter reload on disable", cur_iter, 3);
    cfg_src_mod = 6'd0; cfg_src_base = 32'h0000_FFF8; model_addr = cfg_src_base;
    idle_cycles(2);
    cfg_en = 1'b1;
    push_burst();
    pulse_req();
    idle_cycles(80);
    check(wr_count == 20 && exp_q.size() == 0, "R4 linear burst", wr_count, 20);

    // R9: requests while disabled are forgotten
    cfg_en = 1'b0;
    pulse_req();
    idle_cycles(40);
    wc = wr_count;
    check(wc == 20, "R9 disabled request ignored", wc, 20);
    cfg_en = 1'b1;
    idle_cycles(40);
    check(wr_count == 20 && !rd_valid, "R9 no stale pending", wr_count, 20);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule